// File: doc/BRIEF.md
# Two-Digit BCD to Binary Converter

This block turns a packed two-digit decimal value (tens digit in the upper nibble, units digit in the lower nibble) into its plain binary equal, 0 to 99 in seven bits. It does not multiply the tens digit by ten. Every input bit selects a fixed decimal weight, and a balanced tree of adders sums the selected weights. Each adder is built from chained 4-bit parallel adder slices.

A flag reports a digit outside 0 to 9. When the flag is high the binary result has no defined meaning. Data enters and leaves through valid/ready streams. The parameter `OUT_REG` chooses between two forms. With `OUT_REG = 1` a single output register holds the result, which appears one cycle after acceptance. That register stalls under back-pressure and can take a new value in the same cycle the old one drains. With `OUT_REG = 0` the block is pure logic: valid and ready pass straight through and the result follows the input in the same cycle.

Top module: `bcd2bin_conv`

## Requirements
- R1: A set units bit (bcd_in bits 3..0) adds 1, 2, 4 or 8 to the result, going from bit 0 up to bit 3.
- R2: A set tens bit (bcd_in bits 7..4) adds 10, 20, 40 or 80 to the result, going from bit 4 up to bit 7.
- R3: Input 8'h52 gives bin_out = 7'b0110100 (2 + 10 + 40 = 52).
- R4: For every input whose two nibbles are both 0..9, bin_out equals tens*10 + units, and that value is at most 99.
- R5: bad_digit is 1 exactly when bcd_in[7:4] > 9 or bcd_in[3:0] > 9, and 0 otherwise.
- R6: With OUT_REG = 0, out_valid equals in_valid and in_ready equals out_ready in the same cycle. bin_out and bad_digit follow bcd_in with no clock edge in between.
- R7: With OUT_REG = 1, a word is accepted on a clock edge where in_valid and in_ready are both 1. Its result and flag appear on the outputs after that edge, and out_valid is then 1.
- R8: With OUT_REG = 1, while out_valid is 1 and out_ready is 0, in_ready is 0 and bin_out, bad_digit and out_valid hold their values. in_ready is 1 whenever out_valid is 0 or out_ready is 1.
- R9: With OUT_REG = 1, a clock edge with rst = 1 sets out_valid, bin_out and bad_digit to 0 (synchronous, active high).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the output register |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input word present |
| in_ready | output | 1 | Block takes the input word this cycle |
| bcd_in | input | 8 | Packed BCD: tens in [7:4], units in [3:0] |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result this cycle |
| bin_out | output | 7 | Binary value of the input |
| bad_digit | output | 1 | A nibble is above 9 |

## Verification
The bench builds the block twice at once: with OUT_REG = 1 as the main instance and with OUT_REG = 0 beside it, both fed the same stimulus. The registered build exposes the one-cycle latency, stalls under back-pressure, streams new words while old ones drain, and resets mid-stream. The pure-logic build exposes same-cycle pass-through of valid, ready and data. Both builds see every valid input and every input with a bad digit, so each weight and each flag case is reached in both forms.

// File: rtl/bcd2bin_pkg.sv
package bcd2bin_pkg;
  localparam int DIG_W   = 4;
  localparam int N_DIG   = 2;
  localparam int RADIX   = 10;
  localparam int BCD_W   = DIG_W * N_DIG;
  localparam int BIN_W   = 7;
  localparam int SLICE_W = 4;
  localparam int N_SLICE = 2;
  localparam int ACC_W   = SLICE_W * N_SLICE;
  localparam int N_LEAF  = BCD_W;

  // decimal weight of bit k in packed BCD
  function automatic int bit_weight(input int k);
    int w;
    w = 1;
    for (int d = 0; d < k / DIG_W; d++) w = w * RADIX;
    return w << (k % DIG_W);
  endfunction
endpackage

// File: rtl/bcd2bin_adder4.sv
module bcd2bin_adder4 import bcd2bin_pkg::*; (
  input  logic [SLICE_W-1:0] a,
  input  logic [SLICE_W-1:0] b,
  input  logic               ci,
  output logic [SLICE_W-1:0] s,
  output logic               co
);
  logic [SLICE_W:0] full;
  assign full = {1'b0, a} + {1'b0, b} + {{SLICE_W{1'b0}}, ci};
  assign s  = full[SLICE_W-1:0];
  assign co = full[SLICE_W];
endmodule

// File: rtl/bcd2bin_chain.sv
module bcd2bin_chain import bcd2bin_pkg::*; (
  input  logic [ACC_W-1:0] a,
  input  logic [ACC_W-1:0] b,
  output logic [ACC_W-1:0] s,
  output logic             co
);
  logic [N_SLICE:0] c;
  assign c[0] = 1'b0;
  for (genvar j = 0; j < N_SLICE; j++) begin : g_slice
    bcd2bin_adder4 u_add (
      .a (a[j*SLICE_W +: SLICE_W]),
      .b (b[j*SLICE_W +: SLICE_W]),
      .ci(c[j]),
      .s (s[j*SLICE_W +: SLICE_W]),
      .co(c[j+1])
    );
  end
  assign co = c[N_SLICE];
endmodule

// File: rtl/bcd2bin_digit_chk.sv
module bcd2bin_digit_chk import bcd2bin_pkg::*; (
  input  logic [DIG_W-1:0] digit,
  output logic             over
);
  assign over = (int'(digit) > RADIX - 1);
endmodule

// File: rtl/bcd2bin_conv.sv
module bcd2bin_conv import bcd2bin_pkg::*; #(
  parameter bit OUT_REG = 1'b1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [BCD_W-1:0] bcd_in,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [BIN_W-1:0] bin_out,
  output logic             bad_digit
);
  localparam int N_NODE = 2 * N_LEAF;

  // heap-ordered tree: leaves at N_LEAF..N_NODE-1, root at 1
  logic [ACC_W-1:0] node [1:N_NODE-1];
  logic [N_LEAF-1:1] carry;
  logic [N_DIG-1:0]  over;
  logic              spare;
  logic [BIN_W-1:0]  sum_c;
  logic              bad_c;

  for (genvar k = 0; k < N_LEAF; k++) begin : g_leaf
    localparam logic [ACC_W-1:0] W = ACC_W'(bit_weight(k));
    assign node[N_LEAF + k] = bcd_in[k] ? W : '0;
  end

  for (genvar i = 1; i < N_LEAF; i++) begin : g_node
    bcd2bin_chain u_sum (
      .a (node[2*i]),
      .b (node[2*i+1]),
      .s (node[i]),
      .co(carry[i])
    );
  end

  for (genvar d = 0; d < N_DIG; d++) begin : g_dig
    bcd2bin_digit_chk u_chk (
      .digit(bcd_in[d*DIG_W +: DIG_W]),
      .over (over[d])
    );
  end

  // bits above the result can only be set when a digit is already bad
  assign spare = (|carry) | (|node[1][ACC_W-1:BIN_W]);
  assign sum_c = node[1][BIN_W-1:0];
  assign bad_c = (|over) | spare;

  if (OUT_REG) begin : g_reg
    logic             v_q;
    logic [BIN_W-1:0] sum_q;
    logic             bad_q;
    assign in_ready = !v_q || out_ready;
    always_ff @(posedge clk) begin
      if (rst) begin
        v_q   <= 1'b0;
        sum_q <= '0;
        bad_q <= 1'b0;
      end else if (in_ready) begin
        v_q <= in_valid;
        if (in_valid) begin
          sum_q <= sum_c;
          bad_q <= bad_c;
        end
      end
    end
    assign out_valid = v_q;
    assign bin_out   = sum_q;
    assign bad_digit = bad_q;
  end else begin : g_comb
    assign in_ready  = out_ready;
    assign out_valid = in_valid;
    assign bin_out   = sum_c;
    assign bad_digit = bad_c;
  end
endmodule

// File: rtl/bcd2bin_conv_chk.sv
module bcd2bin_conv_chk import bcd2bin_pkg::*; #(
  parameter bit OUT_REG = 1'b1
) (
  input logic             clk,
  input logic             rst,
  input logic             in_valid,
  input logic             in_ready,
  input logic [BCD_W-1:0] bcd_in,
  input logic             out_valid,
  input logic             out_ready,
  input logic [BIN_W-1:0] bin_out,
  input logic             bad_digit
);
  if (OUT_REG) begin : g_seq
    // R8: stalled result stays put
    a_r8_hold: assert property (@(posedge clk) disable iff (rst)
      out_valid && !out_ready |=> out_valid && $stable(bin_out) && $stable(bad_digit));
    // R8: an empty register always takes input
    a_r8_ready: assert property (@(posedge clk) disable iff (rst)
      !out_valid |-> in_ready);
    // R7: accepted word shows up next cycle
    a_r7_latency: assert property (@(posedge clk) disable iff (rst)
      in_valid && in_ready |=> out_valid);
    // R9: cleared after reset
    a_r9_reset: assert property (@(posedge clk) disable iff (rst)
      $past(rst) |-> !out_valid && bin_out == '0 && !bad_digit);
    // R4: legal result never exceeds 99
    a_r4_range: assert property (@(posedge clk) disable iff (rst)
      out_valid && !bad_digit |-> int'(bin_out) <= 99);
  end else begin : g_comb
    always_comb begin
      if (in_valid && !bad_digit)
        a_r4_range_c: assert (int'(bin_out) <= 99);
      a_r6_pass: assert (out_valid == in_valid && in_ready == out_ready);
    end
  end
  logic unused_in;
  assign unused_in = ^bcd_in;
endmodule

bind bcd2bin_conv bcd2bin_conv_chk #(.OUT_REG(OUT_REG)) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
  .bcd_in(bcd_in), .out_valid(out_valid), .out_ready(out_ready),
  .bin_out(bin_out), .bad_digit(bad_digit)
);

// File: tb/sim_bcd2bin_conv.sv
module sim_bcd2bin_conv;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0;
  logic out_ready = 1'b1;
  logic [7:0] bcd = 8'h00;
  logic rdy0, ov0, bad0, rdy1, ov1, bad1;
  logic [6:0] bin0, bin1;
  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  bcd2bin_conv #(.OUT_REG(1'b1)) u0 (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(rdy0), .bcd_in(bcd),
    .out_valid(ov0), .out_ready(out_ready), .bin_out(bin0), .bad_digit(bad0));
  bcd2bin_conv #(.OUT_REG(1'b0)) u1 (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(rdy1), .bcd_in(bcd),
    .out_valid(ov1), .out_ready(out_ready), .bin_out(bin1), .bad_digit(bad1));

  // {bcd, expected binary, expected flag, tag: 0=R1 1=R2 2=R5}
  localparam logic [17:0] VEC [12] = '{
    {8'h01, 7'd1,  1'b0, 2'd0}, {8'h02, 7'd2,  1'b0, 2'd0},
    {8'h04, 7'd4,  1'b0, 2'd0}, {8'h08, 7'd8,  1'b0, 2'd0},
    {8'h10, 7'd10, 1'b0, 2'd1}, {8'h20, 7'd20, 1'b0, 2'd1},
    {8'h40, 7'd40, 1'b0, 2'd1}, {8'h80, 7'd80, 1'b0, 2'd1},
    {8'h99, 7'd99, 1'b0, 2'd1}, {8'h0A, 7'd0,  1'b1, 2'd2},
    {8'hA0, 7'd0,  1'b1, 2'd2}, {8'hFF, 7'd0,  1'b1, 2'd2}};

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic string tagname(input logic [1:0] t);
    return (t == 2'd0) ? "R1" : (t == 2'd1) ? "R2" : "R5";
  endfunction

  // drive one word; check pure-logic build at once, registered build next cycle
  task automatic send(input logic [7:0] v, input int exp, input bit bad,
                      input string req, input bit chkbin);
    @(negedge clk);
    bcd = v; in_valid = 1'b1;
    #1;
    if (chkbin) chk({req, " comb value"}, int'(bin1), exp);
    chk({req, " comb flag"}, int'(bad1), int'(bad));
    @(negedge clk);
    chk({req, " reg valid"}, int'(ov0), 1);
    if (chkbin) chk({req, " reg value"}, int'(bin0), exp);
    chk({req, " reg flag"}, int'(bad0), int'(bad));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R9 reset valid", int'(ov0), 0);
    chk("R9 reset value", int'(bin0), 0);
    rst = 1'b0;

    for (int i = 0; i < 12; i++)
      send(VEC[i][17:10], int'(VEC[i][9:3]), VEC[i][2], tagname(VEC[i][1:0]), !VEC[i][2]);

    send(8'h52, 52, 1'b0, "R3", 1'b1);
    chk("R3 pattern", int'(bin0 == 7'b0110100), 1);

    for (int t = 0; t < 10; t++)
      for (int u = 0; u < 10; u++)
        send({4'(t), 4'(u)}, t * 10 + u, 1'b0, "R4", 1'b1);

    // R5: every byte, flag on the pure-logic build
    for (int b = 0; b < 256; b++) begin
      @(negedge clk);
      bcd = 8'(b);
      #1;
      chk("R5 flag sweep", int'(bad1), int'((b >> 4) > 9 || (b & 15) > 9));
    end

    // R7: new word not visible before the edge
    send(8'h11, 11, 1'b0, "R7", 1'b1);
    @(negedge clk);
    bcd = 8'h27;
    #1;
    chk("R7 before edge", int'(bin0), 11);
    chk("R6 same cycle", int'(bin1), 27);
    @(negedge clk);
    chk("R7 after edge", int'(bin0), 27);

    // R6: pass-through of handshake
    out_ready = 1'b0; in_valid = 1'b0;
    #1;
    chk("R6 ready through", int'(rdy1), 0);
    chk("R6 valid through", int'(ov1), 0);
    in_valid = 1'b1;
    #1;
    chk("R6 valid follows", int'(ov1), 1);

    // R8: back-pressure
    @(negedge clk);
    bcd = 8'h12;
    @(negedge clk);
    bcd = 8'h34;
    @(negedge clk);
    chk("R8 stall ready", int'(rdy0), 0);
    chk("R8 stall valid", int'(ov0), 1);
    chk("R8 stall value", int'(bin0), 27);
    @(negedge clk);
    chk("R8 still held", int'(bin0), 27);
    out_ready = 1'b1;
    #1;
    chk("R8 ready on drain", int'(rdy0), 1);
    @(negedge clk);
    chk("R8 next word", int'(bin0), 34);
    in_valid = 1'b0;
    @(negedge clk);
    chk("R8 drained", int'(ov0), 0);

    // R9: reset mid-stream
    send(8'h45, 45, 1'b0, "R9 pre", 1'b1);
    rst = 1'b1;
    @(negedge clk);
    chk("R9 mid valid", int'(ov0), 0);
    chk("R9 mid value", int'(bin0), 0);
    rst = 1'b0; in_valid = 1'b0;
    @(negedge clk);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #1500000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule